// File: doc/BRIEF.md
# Fetch-and-Add Combining Queue

This block is the memory-facing output queue of a two-input network switch. Each of its two input streams (an upper port and a lower port) carries fetch-and-add requests made of an address, an addend and a tag. Requests leave through a single output stream toward memory, one per handshake, oldest first. While a request waits, a later request from the same input port to the same address may be folded into it. The folded request then carries the sum of the two addends and a freshly issued tag. For each fold the block emits one record for the switch's wait buffer. That record holds the fresh tag, both original tags and the addend of the older request, which lets the reply path split one memory reply back into two answers.

All three streams use valid/ready. An input request transfers on a clock edge where both valid and ready are high. The output presents the head entry while valid is high and drops it on an edge where ready is also high. Input ready never depends on output ready. Heavy folding is throttled: once more than one folded entry sits in the queue, the usable capacity shrinks from the full depth to a small limit. This pushes back on the senders until the folded entries have drained. A plain `wb_full` input reports that the wait buffer has no room. While it is high, neither input accepts and no fold takes place.

Top module: `fa_combine_queue`

## Requirements
- R1: After reset the queue is empty: `mem_valid` and `wr_valid` are low, and both input readies are high while `wb_full` is low. The fresh-tag counter restarts at 0.
- R2: Requests that do not fold leave in arrival order. When both inputs transfer in the same cycle, the upper-port request is placed ahead of the lower-port request. An entry leaves only on an edge where `mem_valid` and `mem_ready` are both high.
- R3: An incoming request folds into the oldest queued entry that matches all of the following: same address, same input port, not at the head, and not already folded. The incoming request then takes no slot. The entry's addend becomes the sum of both addends, its tag becomes the next value of a 4-bit fresh-tag counter (0, 1, 2, … wrapping), and `mem_combined` reads 1 when the entry reaches the head.
- R4: Each fold raises `wr_valid` for exactly one cycle, the cycle after the accepting edge. The record carries the fresh tag in `wr_tag`, the queued entry's tag in `wr_first_tag`, the incoming tag in `wr_second_tag` and the queued entry's addend (before the fold) in `wr_first_addend`.
- R5: The head entry never folds. While `mem_valid` is high and `mem_ready` is low, the head's address, addend and tag stay unchanged.
- R6: A request never folds with an entry that arrived on the other input port.
- R7: An entry that is already folded is not a fold target. When both inputs would fold in the same cycle, only the upper-port request folds and the lower-port request is appended as a new entry.
- R8: While `wb_full` is high, `up_ready` and `lo_ready` are both low.
- R9: The capacity is 8 entries while at most one queued entry is folded, and 2 entries while two or more are. With `wb_full` low, `up_ready` is high exactly when the occupancy is below the capacity.
- R10: With `wb_full` low, `lo_ready` is high exactly when the occupancy plus `up_valid` is below the capacity. Lower ready therefore implies upper ready.
- R11: A folded addend is the sum of the two addends modulo 2^8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| up_valid | input | 1 | Upper-port request valid |
| up_ready | output | 1 | Upper-port request accepted when high with valid |
| up_addr | input | 8 | Upper-port target address |
| up_addend | input | 8 | Upper-port addend |
| up_tag | input | 4 | Upper-port request tag |
| lo_valid | input | 1 | Lower-port request valid |
| lo_ready | output | 1 | Lower-port request accepted when high with valid |
| lo_addr | input | 8 | Lower-port target address |
| lo_addend | input | 8 | Lower-port addend |
| lo_tag | input | 4 | Lower-port request tag |
| mem_valid | output | 1 | Head entry present toward memory |
| mem_ready | input | 1 | Memory side takes the head entry |
| mem_addr | output | 8 | Head entry address |
| mem_addend | output | 8 | Head entry addend (summed if folded) |
| mem_tag | output | 4 | Head entry tag (fresh if folded) |
| mem_combined | output | 1 | Head entry is a folded request |
| wb_full | input | 1 | Wait buffer cannot take a record |
| wr_valid | output | 1 | Wait-buffer record valid (one cycle per fold) |
| wr_tag | output | 4 | Fresh tag given to the folded request |
| wr_first_tag | output | 4 | Tag of the older (queued) request |
| wr_second_tag | output | 4 | Tag of the incoming request |
| wr_first_addend | output | 8 | Addend of the older request before the fold |

## Verification
The delicate overlap is a fold into the entry directly behind the head on the same edge where the head leaves toward memory. In that case the folded entry moves to the head position and takes its new sum and fresh tag at the same moment. Random traffic confined to four addresses, with `mem_ready` toggling about half the time, produces this case often. A directed sequence builds the reduced-capacity state and then drains it. A bench reference model walks through the same edges. It applies the fold before the head leaves and compares the head fields, the readies and the following cycle's wait-buffer record against its own queue.

// File: rtl/cq_pkg.sv
package cq_pkg;
  localparam int CQ_ADDR_W  = 8;
  localparam int CQ_ADD_W   = 8;
  localparam int CQ_TAG_W   = 4;
  localparam int CQ_DEPTH   = 8;
  localparam int CQ_LOW_CAP = 2;

  typedef enum logic {
    SRC_UP = 1'b0,
    SRC_LO = 1'b1
  } src_e;
endpackage

// File: rtl/cq_match.sv
module cq_match #(
  parameter int DEPTH  = 8,
  parameter int ADDR_W = 8,
  parameter int CNT_W  = $clog2(DEPTH + 1),
  parameter int IDX_W  = $clog2(DEPTH)
) (
  input  logic [DEPTH-1:0][ADDR_W-1:0] e_addr,
  input  logic [DEPTH-1:0]             e_src,
  input  logic [DEPTH-1:0]             e_comb,
  input  logic [CNT_W-1:0]             occ,
  input  logic [ADDR_W-1:0]            req_addr,
  input  logic                         req_src,
  output logic                         hit,
  output logic [IDX_W-1:0]             idx
);
  logic [DEPTH-1:0] elig;

  // slot 0 is the head and may never be a fold target
  assign elig[0] = 1'b0;

  generate
    for (genvar j = 1; j < DEPTH; j++) begin : g_cmp
      assign elig[j] = (occ > CNT_W'(j)) &&
                       (e_addr[j] == req_addr) &&
                       (e_src[j] == req_src) &&
                       !e_comb[j];
    end
  endgenerate

  // the oldest eligible slot wins
  always_comb begin
    hit = 1'b0;
    idx = '0;
    for (int j = DEPTH - 1; j >= 1; j--) begin
      if (elig[j]) begin
        hit = 1'b1;
        idx = IDX_W'(j);
      end
    end
  end
endmodule

// File: rtl/cq_capacity.sv
module cq_capacity #(
  parameter int DEPTH    = 8,
  parameter int FULL_CAP = 8,
  parameter int LOW_CAP  = 2,
  parameter int CNT_W    = $clog2(DEPTH + 1)
) (
  input  logic [DEPTH-1:0] e_comb,
  input  logic [CNT_W-1:0] occ,
  input  logic             wb_full,
  input  logic             up_valid,
  output logic             up_ready,
  output logic             lo_ready
);
  logic [CNT_W-1:0] n_comb;
  logic             reduced;
  logic [CNT_W-1:0] cap;
  logic [CNT_W:0]   lo_need;

  always_comb begin
    n_comb = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if (e_comb[i] && (occ > CNT_W'(i))) n_comb = n_comb + 1'b1;
    end
  end

  assign reduced  = (n_comb > CNT_W'(1));
  assign cap      = reduced ? CNT_W'(LOW_CAP) : CNT_W'(FULL_CAP);
  assign lo_need  = {1'b0, occ} + {{CNT_W{1'b0}}, up_valid};
  assign up_ready = !wb_full && (occ < cap);
  assign lo_ready = !wb_full && (lo_need < {1'b0, cap});
endmodule

// File: rtl/cq_store.sv
module cq_store #(
  parameter int DEPTH  = 8,
  parameter int ADDR_W = 8,
  parameter int ADD_W  = 8,
  parameter int TAG_W  = 4,
  parameter int CNT_W  = $clog2(DEPTH + 1),
  parameter int IDX_W  = $clog2(DEPTH)
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         up_push,
  input  logic [ADDR_W-1:0]            up_addr,
  input  logic [ADD_W-1:0]             up_addend,
  input  logic [TAG_W-1:0]             up_tag,
  input  logic                         lo_push,
  input  logic [ADDR_W-1:0]            lo_addr,
  input  logic [ADD_W-1:0]             lo_addend,
  input  logic [TAG_W-1:0]             lo_tag,
  input  logic                         mg_en,
  input  logic [IDX_W-1:0]             mg_idx,
  input  logic [ADD_W-1:0]             mg_addend,
  input  logic [TAG_W-1:0]             mg_tag,
  input  logic                         pop,
  output logic [DEPTH-1:0][ADDR_W-1:0] e_addr,
  output logic [DEPTH-1:0][ADD_W-1:0]  e_addend,
  output logic [DEPTH-1:0][TAG_W-1:0]  e_tag,
  output logic [DEPTH-1:0]             e_src,
  output logic [DEPTH-1:0]             e_comb,
  output logic [CNT_W-1:0]             occ
);
  import cq_pkg::*;

  logic [DEPTH-1:0][ADDR_W-1:0] n_addr;
  logic [DEPTH-1:0][ADD_W-1:0]  n_addend;
  logic [DEPTH-1:0][TAG_W-1:0]  n_tag;
  logic [DEPTH-1:0]             n_src;
  logic [DEPTH-1:0]             n_comb;
  logic [CNT_W-1:0]             n_occ;
  logic [CNT_W-1:0]             up_slot;
  logic [CNT_W-1:0]             lo_slot;

  always_comb begin
    n_addr   = e_addr;
    n_addend = e_addend;
    n_tag    = e_tag;
    n_src    = e_src;
    n_comb   = e_comb;

    // fold first, on pre-pop slot numbering
    if (mg_en) begin
      n_addend[mg_idx] = e_addend[mg_idx] + mg_addend;
      n_tag[mg_idx]    = mg_tag;
      n_comb[mg_idx]   = 1'b1;
    end

    // head departs: everything moves one slot forward
    if (pop) begin
      for (int i = 0; i < DEPTH - 1; i++) begin
        n_addr[i]   = n_addr[i+1];
        n_addend[i] = n_addend[i+1];
        n_tag[i]    = n_tag[i+1];
        n_src[i]    = n_src[i+1];
        n_comb[i]   = n_comb[i+1];
      end
      n_comb[DEPTH-1] = 1'b0;
    end

    up_slot = occ - CNT_W'(pop);
    lo_slot = up_slot + CNT_W'(up_push);

    for (int i = 0; i < DEPTH; i++) begin
      if (up_push && (CNT_W'(i) == up_slot)) begin
        n_addr[i]   = up_addr;
        n_addend[i] = up_addend;
        n_tag[i]    = up_tag;
        n_src[i]    = SRC_UP;
        n_comb[i]   = 1'b0;
      end
      if (lo_push && (CNT_W'(i) == lo_slot)) begin
        n_addr[i]   = lo_addr;
        n_addend[i] = lo_addend;
        n_tag[i]    = lo_tag;
        n_src[i]    = SRC_LO;
        n_comb[i]   = 1'b0;
      end
    end

    n_occ = lo_slot + CNT_W'(lo_push);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      e_addr   <= '0;
      e_addend <= '0;
      e_tag    <= '0;
      e_src    <= '0;
      e_comb   <= '0;
      occ      <= '0;
    end else begin
      e_addr   <= n_addr;
      e_addend <= n_addend;
      e_tag    <= n_tag;
      e_src    <= n_src;
      e_comb   <= n_comb;
      occ      <= n_occ;
    end
  end
endmodule

// File: rtl/fa_combine_queue.sv
module fa_combine_queue #(
  parameter int ADDR_W  = cq_pkg::CQ_ADDR_W,
  parameter int ADD_W   = cq_pkg::CQ_ADD_W,
  parameter int TAG_W   = cq_pkg::CQ_TAG_W,
  parameter int DEPTH   = cq_pkg::CQ_DEPTH,
  parameter int LOW_CAP = cq_pkg::CQ_LOW_CAP
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              up_valid,
  output logic              up_ready,
  input  logic [ADDR_W-1:0] up_addr,
  input  logic [ADD_W-1:0]  up_addend,
  input  logic [TAG_W-1:0]  up_tag,
  input  logic              lo_valid,
  output logic              lo_ready,
  input  logic [ADDR_W-1:0] lo_addr,
  input  logic [ADD_W-1:0]  lo_addend,
  input  logic [TAG_W-1:0]  lo_tag,
  output logic              mem_valid,
  input  logic              mem_ready,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [ADD_W-1:0]  mem_addend,
  output logic [TAG_W-1:0]  mem_tag,
  output logic              mem_combined,
  input  logic              wb_full,
  output logic              wr_valid,
  output logic [TAG_W-1:0]  wr_tag,
  output logic [TAG_W-1:0]  wr_first_tag,
  output logic [TAG_W-1:0]  wr_second_tag,
  output logic [ADD_W-1:0]  wr_first_addend
);
  import cq_pkg::*;

  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam int IDX_W = $clog2(DEPTH);

  logic [DEPTH-1:0][ADDR_W-1:0] e_addr;
  logic [DEPTH-1:0][ADD_W-1:0]  e_addend;
  logic [DEPTH-1:0][TAG_W-1:0]  e_tag;
  logic [DEPTH-1:0]             e_src;
  logic [DEPTH-1:0]             e_comb;
  logic [CNT_W-1:0]             occ;

  logic             acc_up, acc_lo;
  logic             hit_up, hit_lo;
  logic [IDX_W-1:0] idx_up, idx_lo;
  logic             mg_up, mg_lo, mg_any;
  logic [IDX_W-1:0] mg_idx;
  logic [ADD_W-1:0] mg_addend;
  logic [TAG_W-1:0] mg_second;
  logic [TAG_W-1:0] fresh_tag;
  logic             pop;

  cq_capacity #(
    .DEPTH(DEPTH), .FULL_CAP(DEPTH), .LOW_CAP(LOW_CAP), .CNT_W(CNT_W)
  ) u_cap (
    .e_comb(e_comb), .occ(occ), .wb_full(wb_full), .up_valid(up_valid),
    .up_ready(up_ready), .lo_ready(lo_ready)
  );

  cq_match #(
    .DEPTH(DEPTH), .ADDR_W(ADDR_W), .CNT_W(CNT_W), .IDX_W(IDX_W)
  ) u_match_up (
    .e_addr(e_addr), .e_src(e_src), .e_comb(e_comb), .occ(occ),
    .req_addr(up_addr), .req_src(SRC_UP), .hit(hit_up), .idx(idx_up)
  );

  cq_match #(
    .DEPTH(DEPTH), .ADDR_W(ADDR_W), .CNT_W(CNT_W), .IDX_W(IDX_W)
  ) u_match_lo (
    .e_addr(e_addr), .e_src(e_src), .e_comb(e_comb), .occ(occ),
    .req_addr(lo_addr), .req_src(SRC_LO), .hit(hit_lo), .idx(idx_lo)
  );

  assign acc_up = up_valid && up_ready;
  assign acc_lo = lo_valid && lo_ready;
  // one fold per cycle, upper port takes precedence
  assign mg_up  = acc_up && hit_up && !wb_full;
  assign mg_lo  = acc_lo && hit_lo && !wb_full && !mg_up;
  assign mg_any = mg_up || mg_lo;

  assign mg_idx    = mg_up ? idx_up    : idx_lo;
  assign mg_addend = mg_up ? up_addend : lo_addend;
  assign mg_second = mg_up ? up_tag    : lo_tag;

  assign pop = mem_ready && (occ != '0);

  cq_store #(
    .DEPTH(DEPTH), .ADDR_W(ADDR_W), .ADD_W(ADD_W), .TAG_W(TAG_W),
    .CNT_W(CNT_W), .IDX_W(IDX_W)
  ) u_store (
    .clk(clk), .rst_n(rst_n),
    .up_push(acc_up && !mg_up), .up_addr(up_addr), .up_addend(up_addend), .up_tag(up_tag),
    .lo_push(acc_lo && !mg_lo), .lo_addr(lo_addr), .lo_addend(lo_addend), .lo_tag(lo_tag),
    .mg_en(mg_any), .mg_idx(mg_idx), .mg_addend(mg_addend), .mg_tag(fresh_tag),
    .pop(pop),
    .e_addr(e_addr), .e_addend(e_addend), .e_tag(e_tag), .e_src(e_src),
    .e_comb(e_comb), .occ(occ)
  );

  assign mem_valid    = (occ != '0);
  assign mem_addr     = e_addr[0];
  assign mem_addend   = e_addend[0];
  assign mem_tag      = e_tag[0];
  assign mem_combined = e_comb[0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fresh_tag       <= '0;
      wr_valid        <= 1'b0;
      wr_tag          <= '0;
      wr_first_tag    <= '0;
      wr_second_tag   <= '0;
      wr_first_addend <= '0;
    end else begin
      wr_valid <= mg_any;
      if (mg_any) begin
        fresh_tag       <= fresh_tag + 1'b1;
        wr_tag          <= fresh_tag;
        wr_first_tag    <= e_tag[mg_idx];
        wr_second_tag   <= mg_second;
        wr_first_addend <= e_addend[mg_idx];
      end
    end
  end
endmodule

// File: rtl/cq_checker.sv
module cq_checker #(
  parameter int TAG_W = 4,
  parameter int ADD_W = 8,
  parameter int ADDR_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              up_valid,
  input logic              up_ready,
  input logic [TAG_W-1:0]  up_tag,
  input logic              lo_valid,
  input logic              lo_ready,
  input logic [TAG_W-1:0]  lo_tag,
  input logic              mem_valid,
  input logic              mem_ready,
  input logic [ADDR_W-1:0] mem_addr,
  input logic [ADD_W-1:0]  mem_addend,
  input logic [TAG_W-1:0]  mem_tag,
  input logic              wb_full,
  input logic              wr_valid,
  input logic [TAG_W-1:0]  wr_tag,
  input logic [TAG_W-1:0]  wr_second_tag
);
  logic [TAG_W-1:0] next_fresh;

  always_ff @(posedge clk) begin
    if (!rst_n) next_fresh <= '0;
    else if (wr_valid) next_fresh <= next_fresh + 1'b1;
  end

  // R8
  wb_full_blocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wb_full |-> (!up_ready && !lo_ready));

  // R10
  lo_implies_up_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lo_ready |-> up_ready);

  // R9
  empty_accepts_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_valid && !wb_full) |-> up_ready);

  // R5
  head_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && !mem_ready) |=> (mem_valid && $stable(mem_addr) &&
                                   $stable(mem_addend) && $stable(mem_tag)));

  // R2
  drain_by_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(mem_valid) |-> $past(mem_ready));

  // R4
  rec_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid |-> (($past(up_valid && up_ready) && wr_second_tag == $past(up_tag)) ||
                  ($past(lo_valid && lo_ready) && wr_second_tag == $past(lo_tag))));

  // R3
  fresh_tag_seq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid |-> (wr_tag == next_fresh));
endmodule

bind fa_combine_queue cq_checker #(.TAG_W(TAG_W), .ADD_W(ADD_W), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n),
  .up_valid(up_valid), .up_ready(up_ready), .up_tag(up_tag),
  .lo_valid(lo_valid), .lo_ready(lo_ready), .lo_tag(lo_tag),
  .mem_valid(mem_valid), .mem_ready(mem_ready), .mem_addr(mem_addr),
  .mem_addend(mem_addend), .mem_tag(mem_tag),
  .wb_full(wb_full), .wr_valid(wr_valid), .wr_tag(wr_tag),
  .wr_second_tag(wr_second_tag)
);

// File: tb/tb_fa_combine_queue.sv
`timescale 1ns/1ps
module tb_fa_combine_queue;
  localparam int AW = 8;
  localparam int DW = 8;
  localparam int TW = 4;
  localparam int D  = 8;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst_n;
  logic up_valid, up_ready, lo_valid, lo_ready;
  logic [AW-1:0] up_addr, lo_addr, mem_addr;
  logic [DW-1:0] up_addend, lo_addend, mem_addend, wr_first_addend;
  logic [TW-1:0] up_tag, lo_tag, mem_tag, wr_tag, wr_first_tag, wr_second_tag;
  logic mem_valid, mem_ready, mem_combined, wb_full, wr_valid;

  fa_combine_queue dut (
    .clk(clk), .rst_n(rst_n),
    .up_valid(up_valid), .up_ready(up_ready), .up_addr(up_addr),
    .up_addend(up_addend), .up_tag(up_tag),
    .lo_valid(lo_valid), .lo_ready(lo_ready), .lo_addr(lo_addr),
    .lo_addend(lo_addend), .lo_tag(lo_tag),
    .mem_valid(mem_valid), .mem_ready(mem_ready), .mem_addr(mem_addr),
    .mem_addend(mem_addend), .mem_tag(mem_tag), .mem_combined(mem_combined),
    .wb_full(wb_full), .wr_valid(wr_valid), .wr_tag(wr_tag),
    .wr_first_tag(wr_first_tag), .wr_second_tag(wr_second_tag),
    .wr_first_addend(wr_first_addend)
  );

  int vectors = 0;
  int miscompares = 0;
  bit finished = 1'b0;

  // reference queue
  logic [AW-1:0] ma [D];
  logic [DW-1:0] md [D];
  logic [TW-1:0] mt [D];
  bit            mp [D];
  bit            mc [D];
  int            mocc;
  logic [TW-1:0] ftag;
  bit            erv;
  logic [TW-1:0] ert, erf, ers;
  logic [DW-1:0] era;

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    vectors++;
    if (!ok) begin
      miscompares++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic int cap_now();
    int n = 0;
    for (int i = 0; i < mocc; i++) if (mc[i]) n++;
    return (n > 1) ? 2 : 8;
  endfunction

  task automatic step(input bit uv, input int ua, input int uad, input int ut,
                      input bit lv, input int la, input int lad, input int lt,
                      input bit wb, input bit ordy);
    int cap, hu, hl;
    bit eru, erl, au, al, mu, ml;
    @(negedge clk);
    up_valid = uv; up_addr = AW'(ua); up_addend = DW'(uad); up_tag = TW'(ut);
    lo_valid = lv; lo_addr = AW'(la); lo_addend = DW'(lad); lo_tag = TW'(lt);
    wb_full = wb; mem_ready = ordy;
    #1;
    cap = cap_now();
    eru = !wb && (mocc < cap);
    erl = !wb && ((mocc + int'(uv)) < cap);
    check(up_ready == eru, wb ? "R8" : "R9", "up_ready", up_ready, eru);
    check(lo_ready == erl, wb ? "R8" : "R10", "lo_ready", lo_ready, erl);
    check(mem_valid == (mocc > 0), "R2", "mem_valid", mem_valid, mocc > 0);
    if (mocc > 0) begin
      check(mem_addr == ma[0], "R2", "mem_addr", mem_addr, ma[0]);
      check(mem_addend == md[0], "R3", "mem_addend", mem_addend, md[0]);
      check(mem_tag == mt[0], "R3", "mem_tag", mem_tag, mt[0]);
      check(mem_combined == mc[0], "R3", "mem_combined", mem_combined, mc[0]);
    end
    check(wr_valid == erv, "R4", "wr_valid", wr_valid, erv);
    if (erv) begin
      check(wr_tag == ert, "R4", "wr_tag", wr_tag, ert);
      check(wr_first_tag == erf, "R4", "wr_first_tag", wr_first_tag, erf);
      check(wr_second_tag == ers, "R4", "wr_second_tag", wr_second_tag, ers);
      check(wr_first_addend == era, "R4", "wr_first_addend", wr_first_addend, era);
    end
    // model update for the coming edge
    au = uv && eru;
    al = lv && erl;
    hu = -1; hl = -1;
    for (int j = 1; j < mocc; j++) begin
      if (hu < 0 && ma[j] == AW'(ua) && !mp[j] && !mc[j]) hu = j;
      if (hl < 0 && ma[j] == AW'(la) && mp[j] && !mc[j]) hl = j;
    end
    mu = au && (hu >= 0);
    ml = al && (hl >= 0) && !mu;
    erv = 1'b0;
    if (mu) begin
      erv = 1'b1; ert = ftag; erf = mt[hu]; ers = TW'(ut); era = md[hu];
      md[hu] = md[hu] + DW'(uad); mt[hu] = ftag; mc[hu] = 1'b1; ftag++;
    end else if (ml) begin
      erv = 1'b1; ert = ftag; erf = mt[hl]; ers = TW'(lt); era = md[hl];
      md[hl] = md[hl] + DW'(lad); mt[hl] = ftag; mc[hl] = 1'b1; ftag++;
    end
    if (ordy && mocc > 0) begin
      for (int i = 0; i < mocc - 1; i++) begin
        ma[i] = ma[i+1]; md[i] = md[i+1]; mt[i] = mt[i+1];
        mp[i] = mp[i+1]; mc[i] = mc[i+1];
      end
      mocc--;
    end
    if (au && !mu) begin
      ma[mocc] = AW'(ua); md[mocc] = DW'(uad); mt[mocc] = TW'(ut);
      mp[mocc] = 1'b0; mc[mocc] = 1'b0; mocc++;
    end
    if (al && !ml) begin
      ma[mocc] = AW'(la); md[mocc] = DW'(lad); mt[mocc] = TW'(lt);
      mp[mocc] = 1'b1; mc[mocc] = 1'b0; mocc++;
    end
  endtask

  task automatic idle(input bit ordy);
    step(0, 0, 0, 0, 0, 0, 0, 0, 0, ordy);
  endtask

  task automatic peek_rec(input bit v, input int t, input int f, input int s,
                          input int ad, input string req);
    @(posedge clk); #1;
    check(wr_valid == v, req, "record valid", wr_valid, v);
    if (v) begin
      check(wr_tag == TW'(t), req, "record fresh tag", wr_tag, t);
      check(wr_first_tag == TW'(f), req, "record first tag", wr_first_tag, f);
      check(wr_second_tag == TW'(s), req, "record second tag", wr_second_tag, s);
      check(wr_first_addend == DW'(ad), req, "record first addend", wr_first_addend, ad);
    end
  endtask

  task automatic peek_head(input int ad, input int t, input bit c, input string req);
    @(posedge clk); #1;
    check(mem_valid == 1'b1, req, "head valid", mem_valid, 1);
    check(mem_addend == DW'(ad), req, "head addend", mem_addend, ad);
    check(mem_tag == TW'(t), req, "head tag", mem_tag, t);
    check(mem_combined == c, req, "head combined", mem_combined, c);
  endtask

  initial begin
    #(200000 * 5.0);
    if (!finished) begin
      miscompares++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h00C0FFEE));
    rst_n = 1'b0;
    up_valid = 0; up_addr = '0; up_addend = '0; up_tag = '0;
    lo_valid = 0; lo_addr = '0; lo_addend = '0; lo_tag = '0;
    wb_full = 0; mem_ready = 0;
    mocc = 0; ftag = '0; erv = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R1 reset state
    check(mem_valid == 1'b0, "R1", "mem_valid", mem_valid, 0);
    check(wr_valid == 1'b0, "R1", "wr_valid", wr_valid, 0);
    check(up_ready == 1'b1, "R1", "up_ready", up_ready, 1);
    check(lo_ready == 1'b1, "R1", "lo_ready", lo_ready, 1);

    // directed: fold rules and reduced capacity, memory side stalled
    step(1, 5, 1, 1, 0, 0, 0, 0, 0, 0);
    step(1, 5, 2, 2, 0, 0, 0, 0, 0, 0);
    peek_rec(0, 0, 0, 0, 0, "R5");            // only the head matched
    step(1, 5, 3, 3, 0, 0, 0, 0, 0, 0);
    peek_rec(1, 0, 2, 3, 2, "R3");            // folds into tag 2 entry
    step(0, 0, 0, 0, 1, 5, 4, 4, 0, 0);
    peek_rec(0, 0, 0, 0, 0, "R6");            // other port, no fold
    step(1, 5, 7, 5, 0, 0, 0, 0, 0, 0);
    peek_rec(0, 0, 0, 0, 0, "R7");            // folded entry is no target
    step(1, 5, 8'hFF, 6, 0, 0, 0, 0, 0, 0);
    peek_rec(1, 1, 5, 6, 7, "R11");
    step(1, 6, 1, 7, 1, 6, 1, 8, 0, 0);       // R9: two folded entries, capacity 2
    step(0, 0, 0, 0, 0, 0, 0, 0, 0, 1);
    peek_head(5, 0, 1, "R3");
    step(0, 0, 0, 0, 0, 0, 0, 0, 0, 1);
    peek_head(4, 4, 0, "R6");
    step(0, 0, 0, 0, 0, 0, 0, 0, 0, 1);
    peek_head(6, 1, 1, "R11");                // 7 + FF wraps to 6
    idle(1);
    idle(0);
    step(1, 3, 1, 1, 1, 3, 1, 1, 1, 0);       // R8
    idle(0);
    // dual fold in one cycle: only the upper one folds
    step(1, 9, 1, 1, 0, 0, 0, 0, 0, 0);
    step(1, 9, 2, 2, 1, 9, 3, 3, 0, 0);
    step(1, 9, 4, 4, 1, 9, 5, 5, 0, 0);
    peek_rec(1, 2, 2, 4, 2, "R7");
    repeat (6) idle(1);

    // constrained random traffic over four addresses
    for (int n = 0; n < 4000; n++) begin
      step(($urandom % 10) < 7, $urandom % 4, $urandom % 256, $urandom % 16,
           ($urandom % 10) < 7, $urandom % 4, $urandom % 256, $urandom % 16,
           ($urandom % 16) == 0, ($urandom % 2) == 0);
    end
    repeat (12) idle(1);

    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule